// File: doc/BRIEF.md
# Calendar Field Encoder for a Real-Time Clock

This block holds the running calendar time as binary fields: second, minute, hour, weekday, day of month, month and full year. It shows each field through a byte-wide register port. A control byte selects one of two encodings. In packed-decimal encoding each byte holds two decimal digits, tens in the high nibble and units in the low nibble. In plain binary encoding the byte holds the value itself. The control byte also selects a 24-hour clock or a 12-hour clock with a PM flag. The two-digit year is shown relative to a base year that is fixed by a parameter. A read-only century byte is also provided.

A second port loads a complete binary time in one cycle, and a one-cycle `tick` pulse advances the time by one second. The advance carries through minutes, hours, days and months, follows the leap-year rule and steps the weekday when the day changes. A register write is decoded in the encoding that is selected at the time of the write, and it replaces that one binary field. Reads are combinational from the registered state, so a change of encoding shows at once on `reg_rdata`.

Top module: `rtc_cal_encoder`

## Requirements
- R1: Index 8 is the control byte. Bit 2 set selects binary encoding and clear selects packed decimal. Bit 1 set selects the 24-hour clock. After reset the byte reads 0x02, and its other bits always read 0.
- R2: Indices 0 (second), 1 (minute) and 4 (day of month) read the field value. In binary mode the byte is the value. In decimal mode it is (value/10)*16 + value mod 10.
- R3: Index 2 (hour) in 24-hour mode is the encoded hour. In 12-hour mode, bit 7 is set for hours 12 to 23, and bits 6:0 hold the encoded value of hour mod 12, with 0 shown as 12.
- R4: A write to index 0, 1, 2 or 4 is decoded with the current encoding into the binary field. In decimal mode, decoding is high nibble*10 + low nibble. In 12-hour mode the hour becomes (decoded bits 6:0) mod 12, plus 12 when bit 7 is set.
- R5: Index 3 shows the weekday (0 to 6) encoded as 1 to 7, and index 5 shows the month (0 to 11) encoded as 1 to 12. A write stores the decoded value minus one.
- R6: Index 6 shows (year - BASE_YEAR) mod 100, with a negative remainder raised by 100. A write sets the year to BASE_YEAR plus the decoded value.
- R7: Index 7 shows the encoded value of year/100. Writes to it are ignored.
- R8: A tick advances the seconds. At 59 they wrap to 0 and carry into minutes. Minutes carry into hours at 59, and hours carry into the day at 23. On a day carry the weekday steps, wrapping from 6 to 0.
- R9: The day of month wraps to 1 after the last day of the month. February has 29 days when the year is divisible by 4 and not by 100, or when it is divisible by 400. Month 11 wraps to 0 and increments the year.
- R10: A load has priority over a register write, and a register write has priority over a tick. A tick in the same cycle as a load or a write is dropped.
- R11: Reset gives 00:00:00, weekday 0, day 1, month 0 and year BASE_YEAR.
- R12: The time fields keep their values in every cycle without a load, a write or a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-second advance pulse |
| load_en | input | 1 | Load every binary field from the load inputs |
| load_sec | input | 6 | Binary second to load |
| load_min | input | 6 | Binary minute to load |
| load_hour | input | 5 | Binary hour (0 to 23) to load |
| load_wday | input | 3 | Binary weekday (0 to 6) to load |
| load_mday | input | 5 | Binary day of month (1 to 31) to load |
| load_mon | input | 4 | Binary month (0 to 11) to load |
| load_year | input | YEAR_W | Full year to load |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for both read and write |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Encoded byte at reg_addr |
| time_sec | output | 6 | Binary second |
| time_min | output | 6 | Binary minute |
| time_hour | output | 5 | Binary hour |
| time_wday | output | 3 | Binary weekday |
| time_mday | output | 5 | Binary day of month |
| time_mon | output | 4 | Binary month |
| time_year | output | YEAR_W | Full year |

## Verification
Any wrong carry shows within one tick on the `time_*` outputs, because every stage of the rollover is registered in the same cycle as the tick. A wrong month length or a wrong leap decision appears only at a month end, so the bench loads the last second of every month and of Februaries in leap and non-leap centuries. Encoding faults are combinational and show on `reg_rdata` in the cycle the index is applied. The bench sweeps every hour in all four mode combinations and every second value in both encodings. Decode faults show as a mismatch on `time_*` one edge after the write.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int unsigned REG_AW  = 4;
  localparam int unsigned NUM_FLD = 7;
  localparam int unsigned CTL_BIN = 2;
  localparam int unsigned CTL_H24 = 1;

  typedef enum logic [REG_AW-1:0] {
    IDX_SEC  = 4'd0,
    IDX_MIN  = 4'd1,
    IDX_HOUR = 4'd2,
    IDX_WDAY = 4'd3,
    IDX_MDAY = 4'd4,
    IDX_MON  = 4'd5,
    IDX_YEAR = 4'd6,
    IDX_CENT = 4'd7,
    IDX_CTRL = 4'd8
  } rtc_idx_e;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [2:0] wday;
    logic [4:0] mday;
    logic [3:0] mon;
  } cal_fields_t;

  // binary value (0..99) to register byte
  function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v - tens * 7'd10;
    return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
  endfunction

  // register byte to binary value
  function automatic logic [7:0] dec_val(input logic [7:0] r, input logic bin);
    return bin ? r : (8'(r[7:4]) * 8'd10 + 8'(r[3:0]));
  endfunction

  function automatic logic is_leap(input int unsigned y);
    return ((y % 4) == 0) && (((y % 100) != 0) || ((y % 400) == 0));
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] m, input logic leap);
    logic [4:0] d;
    case (m)
      4'd1:                     d = leap ? 5'd29 : 5'd28;
      4'd3, 4'd5, 4'd8, 4'd10:  d = 5'd30;
      default:                  d = 5'd31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rtc_wr_decode.sv
module rtc_wr_decode
  import rtc_cal_pkg::*;
#(
  parameter int unsigned YEAR_W    = 12,
  parameter int unsigned BASE_YEAR = 2000
) (
  input  logic                we,
  input  logic [REG_AW-1:0]   addr,
  input  logic [7:0]          wdata,
  input  logic                bin,
  input  logic                h24,
  output logic [NUM_FLD-1:0]  fld_we,
  output logic                ctl_we,
  output logic                ctl_bin,
  output logic                ctl_h24,
  output cal_fields_t         wr_f,
  output logic [YEAR_W-1:0]   wr_year
);

  logic [7:0] raw;
  logic [7:0] raw_m1;
  logic [7:0] hraw;
  logic [7:0] h12;

  for (genvar i = 0; i < NUM_FLD; i++) begin : g_sel
    assign fld_we[i] = we && (addr == REG_AW'(i));
  end

  assign ctl_we  = we && (addr == IDX_CTRL);
  assign ctl_bin = wdata[CTL_BIN];
  assign ctl_h24 = wdata[CTL_H24];

  always_comb begin
    raw    = dec_val(wdata, bin);
    raw_m1 = raw - 8'd1;
    hraw   = dec_val({1'b0, wdata[6:0]}, bin);
    h12    = (hraw % 8'd12) + (wdata[7] ? 8'd12 : 8'd0);
    wr_f.sec  = raw[5:0];
    wr_f.min  = raw[5:0];
    wr_f.hour = h24 ? raw[4:0] : h12[4:0];
    wr_f.wday = raw_m1[2:0];
    wr_f.mday = raw[4:0];
    wr_f.mon  = raw_m1[3:0];
    wr_year   = YEAR_W'(BASE_YEAR) + YEAR_W'(raw);
  end

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_cal_pkg::*;
#(
  parameter int unsigned YEAR_W    = 12,
  parameter int unsigned BASE_YEAR = 2000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               load_en,
  input  cal_fields_t        load_f,
  input  logic [YEAR_W-1:0]  load_year,
  input  logic [NUM_FLD-1:0] fld_we,
  input  cal_fields_t        wr_f,
  input  logic [YEAR_W-1:0]  wr_year,
  output cal_fields_t        cur_f,
  output logic [YEAR_W-1:0]  cur_year
);

  cal_fields_t       nxt_f;
  logic [YEAR_W-1:0] nxt_year;
  logic              upd_en;
  logic              any_wr;
  logic              leap;
  logic [4:0]        dim;
  logic              tick_only;

  assign any_wr    = |fld_we;
  assign upd_en    = load_en | any_wr | tick;
  assign tick_only = tick & ~load_en & ~any_wr;

  always_comb begin
    leap     = is_leap(32'(cur_year));
    dim      = month_days(cur_f.mon, leap);
    nxt_f    = cur_f;
    nxt_year = cur_year;
    if (load_en) begin
      nxt_f    = load_f;
      nxt_year = load_year;
    end else if (any_wr) begin
      if (fld_we[IDX_SEC])  nxt_f.sec  = wr_f.sec;
      if (fld_we[IDX_MIN])  nxt_f.min  = wr_f.min;
      if (fld_we[IDX_HOUR]) nxt_f.hour = wr_f.hour;
      if (fld_we[IDX_WDAY]) nxt_f.wday = wr_f.wday;
      if (fld_we[IDX_MDAY]) nxt_f.mday = wr_f.mday;
      if (fld_we[IDX_MON])  nxt_f.mon  = wr_f.mon;
      if (fld_we[IDX_YEAR]) nxt_year   = wr_year;
    end else if (tick) begin
      if (cur_f.sec < 6'd59) begin
        nxt_f.sec = cur_f.sec + 6'd1;
      end else begin
        nxt_f.sec = '0;
        if (cur_f.min < 6'd59) begin
          nxt_f.min = cur_f.min + 6'd1;
        end else begin
          nxt_f.min = '0;
          if (cur_f.hour < 5'd23) begin
            nxt_f.hour = cur_f.hour + 5'd1;
          end else begin
            nxt_f.hour = '0;
            nxt_f.wday = (cur_f.wday >= 3'd6) ? 3'd0 : cur_f.wday + 3'd1;
            if (cur_f.mday < dim) begin
              nxt_f.mday = cur_f.mday + 5'd1;
            end else begin
              nxt_f.mday = 5'd1;
              if (cur_f.mon < 4'd11) begin
                nxt_f.mon = cur_f.mon + 4'd1;
              end else begin
                nxt_f.mon = '0;
                nxt_year  = cur_year + YEAR_W'(1);
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_f.sec  <= '0;
      cur_f.min  <= '0;
      cur_f.hour <= '0;
      cur_f.wday <= '0;
      cur_f.mday <= 5'd1;
      cur_f.mon  <= '0;
      cur_year   <= YEAR_W'(BASE_YEAR);
    end else if (upd_en) begin
      cur_f    <= nxt_f;
      cur_year <= nxt_year;
    end
  end

  // R12: idle cycles keep the time
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en || any_wr || tick) |=> ($stable(cur_f) && $stable(cur_year)));

  // R8: plain second step
  a_r8_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_only && cur_f.sec < 6'd59) |=> (cur_f.sec == $past(cur_f.sec) + 6'd1));

  // R8: second wrap carries
  a_r8_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_only && cur_f.sec == 6'd59) |=> (cur_f.sec == 6'd0));

  // R9: end of year wraps to January 1 and bumps the year
  a_r9_year_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_only && cur_f.sec == 6'd59 && cur_f.min == 6'd59 && cur_f.hour == 5'd23
     && cur_f.mon == 4'd11 && cur_f.mday == 5'd31)
    |=> (cur_year == $past(cur_year) + YEAR_W'(1) && cur_f.mon == 4'd0 && cur_f.mday == 5'd1));

  // R10: a load wins over everything
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cur_f == $past(load_f) && cur_year == $past(load_year)));

endmodule

// File: rtl/rtc_rd_codec.sv
module rtc_rd_codec
  import rtc_cal_pkg::*;
#(
  parameter int unsigned YEAR_W    = 12,
  parameter int unsigned BASE_YEAR = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  cal_fields_t       cur_f,
  input  logic [YEAR_W-1:0] cur_year,
  input  logic              bin,
  input  logic              h24,
  output logic [7:0]        rdata
);

  int         yr_diff;
  int         yr_mod;
  int         yr_cent;
  logic [4:0] h12;
  logic       pm;
  logic [7:0] h12_byte;

  always_comb begin
    yr_diff = int'(cur_year) - int'(BASE_YEAR);
    yr_mod  = yr_diff % 100;
    if (yr_mod < 0) yr_mod = yr_mod + 100;
    yr_cent = int'(cur_year) / 100;
    pm      = (cur_f.hour >= 5'd12);
    h12     = cur_f.hour % 5'd12;
    if (h12 == 5'd0) h12 = 5'd12;
    h12_byte = enc_val(7'(h12), bin);
  end

  always_comb begin
    case (addr)
      IDX_SEC:  rdata = enc_val(7'(cur_f.sec), bin);
      IDX_MIN:  rdata = enc_val(7'(cur_f.min), bin);
      IDX_HOUR: rdata = h24 ? enc_val(7'(cur_f.hour), bin) : {pm, h12_byte[6:0]};
      IDX_WDAY: rdata = enc_val(7'(cur_f.wday) + 7'd1, bin);
      IDX_MDAY: rdata = enc_val(7'(cur_f.mday), bin);
      IDX_MON:  rdata = enc_val(7'(cur_f.mon) + 7'd1, bin);
      IDX_YEAR: rdata = enc_val(7'(yr_mod), bin);
      IDX_CENT: rdata = enc_val(7'(yr_cent), bin);
      IDX_CTRL: rdata = {5'd0, bin, h24, 1'b0};
      default:  rdata = 8'd0;
    endcase
  end

  // R2: decimal seconds never show a units digit above 9
  a_r2_units_digit: assert property (@(posedge clk) disable iff (!rst_n)
    (!bin && addr == IDX_SEC && cur_f.sec < 6'd60) |-> (rdata[3:0] < 4'd10));

  // R3: a 12-hour display never shows hour zero
  a_r3_no_zero_hour: assert property (@(posedge clk) disable iff (!rst_n)
    (!h24 && addr == IDX_HOUR && cur_f.hour < 5'd24) |-> (rdata[6:0] != 7'd0));

endmodule

// File: rtl/rtc_cal_encoder.sv
module rtc_cal_encoder
  import rtc_cal_pkg::*;
#(
  parameter int unsigned YEAR_W    = 12,
  parameter int unsigned BASE_YEAR = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_en,
  input  logic [5:0]        load_sec,
  input  logic [5:0]        load_min,
  input  logic [4:0]        load_hour,
  input  logic [2:0]        load_wday,
  input  logic [4:0]        load_mday,
  input  logic [3:0]        load_mon,
  input  logic [YEAR_W-1:0] load_year,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [5:0]        time_sec,
  output logic [5:0]        time_min,
  output logic [4:0]        time_hour,
  output logic [2:0]        time_wday,
  output logic [4:0]        time_mday,
  output logic [3:0]        time_mon,
  output logic [YEAR_W-1:0] time_year
);

  logic [1:0]         rst_sync;
  logic               rst_i_n;
  logic               bin_q;
  logic               h24_q;
  logic [NUM_FLD-1:0] fld_we;
  logic               ctl_we;
  logic               ctl_bin;
  logic               ctl_h24;
  cal_fields_t        wr_f;
  logic [YEAR_W-1:0]  wr_year;
  cal_fields_t        load_f;
  cal_fields_t        cur_f;
  logic [YEAR_W-1:0]  cur_year;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      bin_q <= 1'b0;
      h24_q <= 1'b1;
    end else if (ctl_we) begin
      bin_q <= ctl_bin;
      h24_q <= ctl_h24;
    end
  end

  assign load_f = '{sec: load_sec, min: load_min, hour: load_hour,
                    wday: load_wday, mday: load_mday, mon: load_mon};

  rtc_wr_decode #(.YEAR_W(YEAR_W), .BASE_YEAR(BASE_YEAR)) u_dec (
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .bin(bin_q), .h24(h24_q),
    .fld_we(fld_we), .ctl_we(ctl_we), .ctl_bin(ctl_bin), .ctl_h24(ctl_h24),
    .wr_f(wr_f), .wr_year(wr_year)
  );

  rtc_time_core #(.YEAR_W(YEAR_W), .BASE_YEAR(BASE_YEAR)) u_core (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .load_en(load_en),
    .load_f(load_f), .load_year(load_year), .fld_we(fld_we),
    .wr_f(wr_f), .wr_year(wr_year), .cur_f(cur_f), .cur_year(cur_year)
  );

  rtc_rd_codec #(.YEAR_W(YEAR_W), .BASE_YEAR(BASE_YEAR)) u_rd (
    .clk(clk), .rst_n(rst_i_n), .addr(reg_addr), .cur_f(cur_f), .cur_year(cur_year),
    .bin(bin_q), .h24(h24_q), .rdata(reg_rdata)
  );

  assign time_sec  = cur_f.sec;
  assign time_min  = cur_f.min;
  assign time_hour = cur_f.hour;
  assign time_wday = cur_f.wday;
  assign time_mday = cur_f.mday;
  assign time_mon  = cur_f.mon;
  assign time_year = cur_year;

  // R1: control write lands on the next edge
  a_r1_ctrl_write: assert property (@(posedge clk) disable iff (!rst_i_n)
    ctl_we |=> (bin_q == $past(reg_wdata[2]) && h24_q == $past(reg_wdata[1])));

endmodule

// File: tb/rtc_cal_encoder_test.sv
module rtc_cal_encoder_test;

  localparam int YW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          load_en = 1'b0;
  logic [5:0]    load_sec = '0;
  logic [5:0]    load_min = '0;
  logic [4:0]    load_hour = '0;
  logic [2:0]    load_wday = '0;
  logic [4:0]    load_mday = 5'd1;
  logic [3:0]    load_mon = '0;
  logic [YW-1:0] load_year = 12'd2000;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [5:0]    time_sec;
  logic [5:0]    time_min;
  logic [4:0]    time_hour;
  logic [2:0]    time_wday;
  logic [4:0]    time_mday;
  logic [3:0]    time_mon;
  logic [YW-1:0] time_year;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_cal_encoder uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(load_en),
    .load_sec(load_sec), .load_min(load_min), .load_hour(load_hour),
    .load_wday(load_wday), .load_mday(load_mday), .load_mon(load_mon),
    .load_year(load_year), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_sec(time_sec),
    .time_min(time_min), .time_hour(time_hour), .time_wday(time_wday),
    .time_mday(time_mday), .time_mon(time_mon), .time_year(time_year)
  );

  function automatic int e_enc(input int v, input bit bin);
    return bin ? v : ((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int e_hour(input int h, input bit bin, input bit h24);
    int hh;
    if (h24) return e_enc(h, bin);
    hh = h % 12;
    if (hh == 0) hh = 12;
    return e_enc(hh, bin) + ((h >= 12) ? 128 : 0);
  endfunction

  function automatic int e_dim(input int m, input int y);
    bit lp;
    lp = ((y % 4) == 0) && (((y % 100) != 0) || ((y % 400) == 0));
    if (m == 1) return lp ? 29 : 28;
    if (m == 3 || m == 5 || m == 8 || m == 10) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 v = int'(reg_rdata);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic ld(input int s, input int mi, input int h, input int w,
                    input int d, input int mo, input int y);
    @(negedge clk);
    load_en = 1'b1;
    load_sec = 6'(s); load_min = 6'(mi); load_hour = 5'(h);
    load_wday = 3'(w); load_mday = 5'(d); load_mon = 4'(mo); load_year = 12'(y);
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_mode(input bit bin, input bit h24);
    wr(8, (bin ? 4 : 0) + (h24 ? 2 : 0));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 / R1 reset state
    rd(8, v); chk("R1 ctrl reset", v, 8'h02);
    rd(0, v); chk("R11 sec reset", v, 0);
    rd(2, v); chk("R11 hour reset", v, 0);
    rd(3, v); chk("R11 wday reset", v, 1);
    rd(4, v); chk("R11 mday reset", v, 1);
    rd(5, v); chk("R11 mon reset", v, 1);
    rd(6, v); chk("R11 year reset", v, 0);
    chk("R11 time_year reset", int'(time_year), 2000);

    // R1 unused control bits read zero
    wr(8, 8'hFF); rd(8, v); chk("R1 ctrl bits", v, 8'h06);

    // R2 second/minute/day sweep in both encodings
    for (int b = 0; b < 2; b++) begin
      set_mode(b[0], 1'b1);
      for (int s = 0; s < 60; s++) begin
        ld(s, 59 - s, 5, 0, (s % 31) + 1, 0, 2000);
        rd(0, v); chk("R2 sec", v, e_enc(s, b[0]));
        rd(1, v); chk("R2 min", v, e_enc(59 - s, b[0]));
        rd(4, v); chk("R2 mday", v, e_enc((s % 31) + 1, b[0]));
      end
      // R4 write decode of sec and mday
      wr(0, e_enc(37, b[0])); chk("R4 sec write", int'(time_sec), 37);
      wr(4, e_enc(19, b[0])); chk("R4 mday write", int'(time_mday), 19);
    end

    // R3 / R4 hour sweep over all four mode combinations
    for (int m = 0; m < 4; m++) begin
      set_mode(m[0], m[1]);
      for (int h = 0; h < 24; h++) begin
        ld(0, 0, h, 0, 1, 0, 2000);
        rd(2, v); chk("R3 hour read", v, e_hour(h, m[0], m[1]));
        ld(0, 0, (h + 7) % 24, 0, 1, 0, 2000);
        wr(2, e_hour(h, m[0], m[1]));
        chk("R4 hour write", int'(time_hour), h);
      end
    end

    // R5 weekday and month offsets
    for (int b = 0; b < 2; b++) begin
      set_mode(b[0], 1'b1);
      for (int w = 0; w < 7; w++) begin
        ld(0, 0, 0, w, 1, w, 2000);
        rd(3, v); chk("R5 wday read", v, e_enc(w + 1, b[0]));
      end
      for (int mo = 0; mo < 12; mo++) begin
        ld(0, 0, 0, 0, 1, mo, 2000);
        rd(5, v); chk("R5 mon read", v, e_enc(mo + 1, b[0]));
      end
      wr(3, e_enc(4, b[0])); chk("R5 wday write", int'(time_wday), 3);
      wr(5, e_enc(12, b[0])); chk("R5 mon write", int'(time_mon), 11);
    end

    // R6 / R7 year and century
    set_mode(1'b0, 1'b1);
    ld(0, 0, 0, 0, 1, 0, 1999);
    rd(6, v); chk("R6 year below base", v, 8'h99);
    rd(7, v); chk("R7 century 19", v, 8'h19);
    ld(0, 0, 0, 0, 1, 0, 2123);
    rd(6, v); chk("R6 year above", v, 8'h23);
    rd(7, v); chk("R7 century 21", v, 8'h21);
    wr(7, 8'h55);
    rd(7, v); chk("R7 century write ignored", v, 8'h21);
    chk("R7 year untouched", int'(time_year), 2123);
    wr(6, 8'h45); chk("R6 year write", int'(time_year), 2045);
    set_mode(1'b1, 1'b1);
    ld(0, 0, 0, 0, 1, 0, 1999);
    rd(6, v); chk("R6 year binary", v, 99);
    rd(7, v); chk("R7 century binary", v, 19);
    wr(6, 77); chk("R6 year write binary", int'(time_year), 2077);

    // R8 plain step and carries
    ld(10, 0, 0, 0, 1, 0, 2000);
    ticks(1); chk("R8 sec step", int'(time_sec), 11);
    ld(59, 12, 3, 0, 1, 0, 2000);
    ticks(1);
    chk("R8 sec wrap", int'(time_sec), 0);
    chk("R8 min carry", int'(time_min), 13);
    ld(59, 59, 23, 6, 10, 4, 2000);
    ticks(1);
    chk("R8 hour wrap", int'(time_hour), 0);
    chk("R8 wday wrap", int'(time_wday), 0);
    chk("R8 day carry", int'(time_mday), 11);

    // R9 every month end of 2023
    for (int mo = 0; mo < 12; mo++) begin
      ld(59, 59, 23, 3, e_dim(mo, 2023), mo, 2023);
      ticks(1);
      chk("R9 mday wrap", int'(time_mday), 1);
      chk("R9 mon step", int'(time_mon), (mo + 1) % 12);
      chk("R9 year", int'(time_year), (mo == 11) ? 2024 : 2023);
      chk("R8 wday step", int'(time_wday), 4);
    end

    // R9 leap February cases
    begin
      int yrs[4] = '{1900, 2000, 2024, 2023};
      for (int i = 0; i < 4; i++) begin
        ld(59, 59, 23, 0, 28, 1, yrs[i]);
        ticks(1);
        chk("R9 feb 28 next", int'(time_mday), (e_dim(1, yrs[i]) == 29) ? 29 : 1);
        chk("R9 feb 28 mon", int'(time_mon), (e_dim(1, yrs[i]) == 29) ? 1 : 2);
      end
    end
    ld(59, 59, 23, 0, 29, 1, 2024);
    ticks(1);
    chk("R9 leap day end", int'(time_mday), 1);
    chk("R9 leap day mon", int'(time_mon), 2);

    // R10 priorities
    ld(20, 0, 0, 0, 1, 0, 2000);
    @(negedge clk);
    tick = 1'b1; reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 8'd30;
    @(negedge clk);
    tick = 1'b0; reg_we = 1'b0;
    chk("R10 write beats tick", int'(time_sec), 30);
    @(negedge clk);
    tick = 1'b1; load_en = 1'b1; load_sec = 6'd5; load_min = 6'd3;
    reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 8'd44;
    @(negedge clk);
    tick = 1'b0; load_en = 1'b0; reg_we = 1'b0;
    chk("R10 load beats tick", int'(time_sec), 5);
    chk("R10 load beats write", int'(time_min), 3);

    // R12 idle hold
    repeat (5) @(negedge clk);
    chk("R12 hold sec", int'(time_sec), 5);

    summary();
  end

endmodule